// File: doc/BRIEF.md
# CEC Request Dispatcher and Confirmer

This block sits between a host mailbox and a bit-level CEC line engine. When the mailbox signals that a host frame is complete, the dispatcher checks the frame header. If the header fails a check, the block answers at once with a confirmation frame. If it passes, the block hands the address byte to the line engine and starts a transaction. Each result code the engine returns is either turned into the confirmation or leads to another attempt, within a retry budget that software sets.

On the receive side, the block decides whether a message to a given destination logical address is acknowledged. It does this by looking the address up in a 15-bit acknowledge mask. When an acknowledged reception ends, the block loads an indication frame header into the mailbox, which may be a plain indication or an error indication. It also holds the control, acknowledge-mask and configuration registers and the last error code. Turning the block off and resetting it through software both wait until the line is idle before they take effect.

Top module: `cec_dispatch`

## Requirements
- R1: A request arriving while the block is disabled (control register 03h bit 6 clear) starts no line transaction and is answered with a confirmation frame whose count is 3, service 01h and result 80h.
- R2: When enabled, a request whose service byte is not 00h, or whose count byte is below 3, is answered with result 81h and starts no transaction. The disabled check takes precedence over both.
- R3: A valid request pulses `tx_start` with `tx_addr` equal to the request's address byte (source in bits 7:4, destination in bits 3:0). An engine result of 00h gives a confirmation with result 00h.
- R4: Results 83h, 85h and 86h are retryable. The block reissues the transaction until the retry budget is spent, for at most 1 + budget attempts in total, and the confirmation carries the result of the last attempt.
- R5: Results 82h and 84h are never retried; the confirmation follows the first such result directly.
- R6: The budget is configuration register 06h bits 2:0. Values 6 and 7 act as 5.
- R7: A request that arrives while a transaction is in flight is ignored: it causes no new attempt and no confirmation.
- R8: `rx_ack` is high only when the block is enabled and the mask bit for `rx_dest` is set. Register 05h bit n covers address n, register 04h bit n covers address 8+n, and address 15 is never acknowledged.
- R9: An acknowledged reception that ends with no error loads a frame with service 81h and count 2 + `rx_nbytes`. A reception that was not acknowledged loads nothing.
- R10: A reception error (code 2 = no end-of-message, code 3 = overrun) is stored in register 01h and raises `err_flag`, and reading register 01h clears `err_flag`. With configuration bit 4 set, an overrun loads service 82h with count 2, and a code-2 error loads service 83h with count 2 + `rx_nbytes`. With bit 4 clear, an overrun loads nothing and a code-2 error loads 81h.
- R11: Writing control bit 6 to 0 while a transaction or reception is in progress leaves the block enabled until both have finished.
- R12: Writing control bit 7 to 1 is deferred in the same way. Once applied, it restores every register to its reset value: all zero except the version register 02h, which reads 21h.
- R13: When a confirmation and an indication become ready in the same cycle, the confirmation is loaded first and the indication in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host frame complete in mailbox (one-cycle pulse) |
| req_len | input | 8 | Frame count byte of the host frame |
| req_svc | input | 8 | Service byte of the host frame |
| req_addr | input | 8 | Address byte (source:destination) |
| out_load | output | 1 | Load a frame header into the mailbox |
| out_len | output | 8 | Count byte of the loaded frame |
| out_svc | output | 8 | Service byte of the loaded frame |
| out_code | output | 8 | Result code (confirmation frames only, else 00h) |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address, 1 to 6 |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| err_flag | output | 1 | Unread error pending |
| tx_start | output | 1 | Start one line transaction |
| tx_addr | output | 8 | Address byte for the transaction |
| tx_done | input | 1 | Transaction finished |
| tx_result | input | 8 | Result code of the transaction |
| rx_start | input | 1 | Reception header byte seen |
| rx_dest | input | 4 | Destination logical address of the reception |
| rx_ack | output | 1 | Acknowledge decision for `rx_dest` |
| rx_done | input | 1 | Reception finished |
| rx_err | input | 2 | Reception error code |
| rx_nbytes | input | 5 | Received byte count including the address byte |

## Verification
The hardest case to reach is a confirmation and an indication competing for the mailbox in the same cycle. The bench arranges it by opening an acknowledged reception, then sending a request with a bad service byte and ending the reception exactly one cycle later. This lines up the registered confirmation with the reception's completion. The deferred off and deferred reset cases are reached in a similar way: the register write is issued while the bench's line-engine model is deliberately holding a reception or a slow transaction open.

// File: rtl/cec_disp_pkg.sv
package cec_disp_pkg;

  localparam logic [7:0] SVC_REQ = 8'h00;
  localparam logic [7:0] SVC_CNF = 8'h01;
  localparam logic [7:0] SVC_IND = 8'h81;
  localparam logic [7:0] SVC_ERR = 8'h82;
  localparam logic [7:0] SVC_IER = 8'h83;

  localparam logic [7:0] RES_OK       = 8'h00;
  localparam logic [7:0] RES_OFF      = 8'h80;
  localparam logic [7:0] RES_BADREQ   = 8'h81;
  localparam logic [7:0] RES_LINE     = 8'h82;
  localparam logic [7:0] RES_ARB      = 8'h83;
  localparam logic [7:0] RES_BITTIME  = 8'h84;
  localparam logic [7:0] RES_NAK_DST  = 8'h85;
  localparam logic [7:0] RES_NAK_DATA = 8'h86;

  localparam logic [1:0] ER_NONE = 2'd0;
  localparam logic [1:0] ER_LONG = 2'd2;
  localparam logic [1:0] ER_OVR  = 2'd3;

  localparam logic [2:0] RA_ERR  = 3'd1;
  localparam logic [2:0] RA_VER  = 3'd2;
  localparam logic [2:0] RA_CTRL = 3'd3;
  localparam logic [2:0] RA_ACKH = 3'd4;
  localparam logic [2:0] RA_ACKL = 3'd5;
  localparam logic [2:0] RA_CONF = 3'd6;

  typedef enum logic [1:0] {TX_IDLE, TX_ISSUE, TX_WAIT} tx_state_t;

  function automatic logic [2:0] retry_budget(input logic [2:0] field, input logic [2:0] cap);
    return (field > cap) ? cap : field;
  endfunction

  function automatic logic is_retryable(input logic [7:0] code);
    return (code == RES_ARB) || (code == RES_NAK_DST) || (code == RES_NAK_DATA);
  endfunction

  // RES_OK means the header passed every check
  function automatic logic [7:0] req_verdict(input logic on, input logic [7:0] svc,
                                             input logic [7:0] len);
    if (!on) return RES_OFF;
    if (svc != SVC_REQ) return RES_BADREQ;
    if (len < 8'd3) return RES_BADREQ;
    return RES_OK;
  endfunction

  function automatic logic ack_hit(input logic [15:0] mask_ext, input logic [3:0] dest);
    return (dest == 4'hF) ? 1'b0 : mask_ext[dest];
  endfunction

  // SVC_REQ doubles as "no frame"
  function automatic logic [7:0] rx_frame_svc(input logic [1:0] err, input logic err_en);
    if (err == ER_OVR) return err_en ? SVC_ERR : SVC_REQ;
    if (err != ER_NONE && err_en) return SVC_IER;
    return SVC_IND;
  endfunction

  function automatic logic [7:0] rx_frame_len(input logic [7:0] svc, input logic [4:0] nbytes);
    return (svc == SVC_ERR) ? 8'd2 : 8'd2 + {3'b000, nbytes};
  endfunction

endpackage

// File: rtl/cec_cfg_regs.sv
module cec_cfg_regs
  import cec_disp_pkg::*;
#(
  parameter int unsigned LA_COUNT = 15,
  parameter logic [7:0]  VERSION  = 8'h21
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic       reg_re,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       tx_busy,
  input  logic       rx_start,
  input  logic [3:0] rx_dest,
  input  logic       rx_done,
  input  logic [1:0] rx_err,
  output logic       rx_ack,
  output logic       rx_fwd,
  output logic       on,
  output logic       err_en,
  output logic [2:0] retry,
  output logic       err_flag
);
  localparam int unsigned HI_W = LA_COUNT - 8;

  logic            on_q, want_on_q, rst_pend_q;
  logic [HI_W-1:0] ackh_q;
  logic [7:0]      ackl_q;
  logic            err_en_q;
  logic [2:0]      retry_q;
  logic [7:0]      cer_q;
  logic            err_q;
  logic            rx_active_q, rx_acc_q;

  // named events for the checks below
  logic idle, rst_fire, off_fire, new_err, cer_read;
  assign idle     = !tx_busy && !rx_active_q;
  assign rst_fire = rst_pend_q && idle;
  assign off_fire = on_q && !want_on_q && idle;
  assign new_err  = rx_done && rx_acc_q && (rx_err != ER_NONE);
  assign cer_read = reg_re && (reg_addr == RA_ERR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q <= 1'b0; want_on_q <= 1'b0; rst_pend_q <= 1'b0;
      ackh_q <= '0; ackl_q <= '0; err_en_q <= 1'b0; retry_q <= '0;
      cer_q <= '0; err_q <= 1'b0; rx_active_q <= 1'b0; rx_acc_q <= 1'b0;
    end else if (rst_fire) begin
      on_q <= 1'b0; want_on_q <= 1'b0; rst_pend_q <= 1'b0;
      ackh_q <= '0; ackl_q <= '0; err_en_q <= 1'b0; retry_q <= '0;
      cer_q <= '0; err_q <= 1'b0; rx_active_q <= 1'b0; rx_acc_q <= 1'b0;
    end else begin
      if (off_fire) on_q <= 1'b0;
      if (reg_we) begin
        case (reg_addr)
          RA_CTRL: begin
            want_on_q  <= reg_wdata[6];
            if (reg_wdata[6]) on_q <= 1'b1;
            rst_pend_q <= rst_pend_q | reg_wdata[7];
          end
          RA_ACKH: ackh_q <= reg_wdata[HI_W-1:0];
          RA_ACKL: ackl_q <= reg_wdata;
          RA_CONF: begin
            err_en_q <= reg_wdata[4];
            retry_q  <= reg_wdata[2:0];
          end
          default: ;
        endcase
      end
      if (rx_start && !rx_active_q) begin
        rx_active_q <= 1'b1;
        rx_acc_q    <= rx_ack;
      end
      if (cer_read) err_q <= 1'b0;
      if (rx_done) begin
        rx_active_q <= 1'b0;
        if (new_err) begin
          cer_q <= {6'b0, rx_err};
          err_q <= 1'b1;
        end
      end
    end
  end

  assign rx_ack   = on_q && ack_hit(16'({ackh_q, ackl_q}), rx_dest);
  assign rx_fwd   = rx_done && rx_acc_q;
  assign on       = on_q;
  assign err_en   = err_en_q;
  assign retry    = retry_q;
  assign err_flag = err_q;

  always_comb begin
    case (reg_addr)
      RA_ERR:  reg_rdata = cer_q;
      RA_VER:  reg_rdata = VERSION;
      RA_CTRL: reg_rdata = {rst_pend_q, on_q, 6'b0};
      RA_ACKH: reg_rdata = 8'(ackh_q);
      RA_ACKL: reg_rdata = ackl_q;
      RA_CONF: reg_rdata = {3'b0, err_en_q, 1'b0, retry_q};
      default: reg_rdata = 8'h00;
    endcase
  end

  // R11
  off_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(on_q) |-> $past(idle));
  // R10
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cer_read && !new_err) |=> !err_q);
  // R12
  rst_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_fire |=> (!on_q && ackl_q == 8'h00 && ackh_q == '0 && !rst_pend_q && retry_q == 3'd0));

endmodule

// File: rtl/cec_tx_seq.sv
module cec_tx_seq
  import cec_disp_pkg::*;
#(
  parameter logic [2:0] MAX_RETRY = 3'd5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [7:0] req_len,
  input  logic [7:0] req_svc,
  input  logic [7:0] req_addr,
  input  logic       on,
  input  logic [2:0] retry,
  output logic       tx_start,
  output logic [7:0] tx_addr,
  input  logic       tx_done,
  input  logic [7:0] tx_result,
  output logic       tx_busy,
  output logic       cnf_v,
  output logic [7:0] cnf_code
);
  tx_state_t  state_q;
  logic [2:0] budget_q, tries_q;
  logic [7:0] addr_q, code_q;
  logic       cnf_q;

  logic [7:0] verdict;
  logic       again;
  assign verdict = req_verdict(on, req_svc, req_len);
  assign again   = is_retryable(tx_result) && (tries_q < budget_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE; budget_q <= '0; tries_q <= '0;
      addr_q <= '0; code_q <= '0; cnf_q <= 1'b0;
    end else begin
      cnf_q <= 1'b0;
      case (state_q)
        TX_IDLE: if (req_valid) begin
          if (verdict != RES_OK) begin
            cnf_q  <= 1'b1;
            code_q <= verdict;
          end else begin
            addr_q   <= req_addr;
            budget_q <= retry_budget(retry, MAX_RETRY);
            tries_q  <= '0;
            state_q  <= TX_ISSUE;
          end
        end
        TX_ISSUE: state_q <= TX_WAIT;
        TX_WAIT: if (tx_done) begin
          if (again) begin
            tries_q <= tries_q + 3'd1;
            state_q <= TX_ISSUE;
          end else begin
            cnf_q   <= 1'b1;
            code_q  <= tx_result;
            state_q <= TX_IDLE;
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  assign tx_start = (state_q == TX_ISSUE);
  assign tx_addr  = addr_q;
  assign tx_busy  = (state_q != TX_IDLE);
  assign cnf_v    = cnf_q;
  assign cnf_code = code_q;

  // R4
  retry_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tries_q <= budget_q);
  // R3
  cnf_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnf_q |=> !cnf_q);
  // R5
  no_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TX_WAIT && tx_done && !is_retryable(tx_result)) |=> (cnf_q && state_q == TX_IDLE));
  // R7
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TX_WAIT && !tx_done) |=> (state_q == TX_WAIT && !cnf_q));

endmodule

// File: rtl/cec_frame_out.sv
module cec_frame_out
  import cec_disp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnf_v,
  input  logic [7:0] cnf_code,
  input  logic       rx_fwd,
  input  logic [1:0] rx_err,
  input  logic [4:0] rx_nbytes,
  input  logic       err_en,
  output logic       out_load,
  output logic [7:0] out_len,
  output logic [7:0] out_svc,
  output logic [7:0] out_code
);
  logic [7:0] rx_svc, rx_len;
  logic       rx_want;
  assign rx_svc  = rx_frame_svc(rx_err, err_en);
  assign rx_len  = rx_frame_len(rx_svc, rx_nbytes);
  assign rx_want = rx_fwd && (rx_svc != SVC_REQ);

  logic       hold_v;
  logic [7:0] hold_svc, hold_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_load <= 1'b0; out_len <= '0; out_svc <= '0; out_code <= '0;
      hold_v <= 1'b0; hold_svc <= '0; hold_len <= '0;
    end else begin
      out_load <= 1'b0;
      if (cnf_v) begin
        out_load <= 1'b1; out_len <= 8'd3; out_svc <= SVC_CNF; out_code <= cnf_code;
        if (rx_want) begin
          hold_v <= 1'b1; hold_svc <= rx_svc; hold_len <= rx_len;
        end
      end else if (hold_v) begin
        out_load <= 1'b1; out_len <= hold_len; out_svc <= hold_svc; out_code <= 8'h00;
        hold_v <= rx_want;
        if (rx_want) begin
          hold_svc <= rx_svc; hold_len <= rx_len;
        end
      end else if (rx_want) begin
        out_load <= 1'b1; out_len <= rx_len; out_svc <= rx_svc; out_code <= 8'h00;
      end
    end
  end

  // R13
  hold_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_v && rx_want) |-> !cnf_v);
  // R13
  hold_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnf_v && rx_want) |=> (out_svc == SVC_CNF && hold_v));

endmodule

// File: rtl/cec_dispatch.sv
module cec_dispatch
  import cec_disp_pkg::*;
#(
  parameter int unsigned LA_COUNT  = 15,
  parameter logic [2:0]  MAX_RETRY = 3'd5,
  parameter logic [7:0]  VERSION   = 8'h21
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [7:0] req_len,
  input  logic [7:0] req_svc,
  input  logic [7:0] req_addr,
  output logic       out_load,
  output logic [7:0] out_len,
  output logic [7:0] out_svc,
  output logic [7:0] out_code,
  input  logic       reg_we,
  input  logic       reg_re,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       err_flag,
  output logic       tx_start,
  output logic [7:0] tx_addr,
  input  logic       tx_done,
  input  logic [7:0] tx_result,
  input  logic       rx_start,
  input  logic [3:0] rx_dest,
  output logic       rx_ack,
  input  logic       rx_done,
  input  logic [1:0] rx_err,
  input  logic [4:0] rx_nbytes
);
  logic       on, err_en, tx_busy, rx_fwd, cnf_v;
  logic [2:0] retry;
  logic [7:0] cnf_code;

  cec_cfg_regs #(.LA_COUNT(LA_COUNT), .VERSION(VERSION)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tx_busy(tx_busy),
    .rx_start(rx_start), .rx_dest(rx_dest), .rx_done(rx_done), .rx_err(rx_err),
    .rx_ack(rx_ack), .rx_fwd(rx_fwd), .on(on), .err_en(err_en), .retry(retry),
    .err_flag(err_flag)
  );

  cec_tx_seq #(.MAX_RETRY(MAX_RETRY)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_len(req_len), .req_svc(req_svc), .req_addr(req_addr),
    .on(on), .retry(retry), .tx_start(tx_start), .tx_addr(tx_addr),
    .tx_done(tx_done), .tx_result(tx_result), .tx_busy(tx_busy),
    .cnf_v(cnf_v), .cnf_code(cnf_code)
  );

  cec_frame_out u_out (
    .clk(clk), .rst_n(rst_n), .cnf_v(cnf_v), .cnf_code(cnf_code),
    .rx_fwd(rx_fwd), .rx_err(rx_err), .rx_nbytes(rx_nbytes), .err_en(err_en),
    .out_load(out_load), .out_len(out_len), .out_svc(out_svc), .out_code(out_code)
  );

  // R1
  off_no_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !on && !tx_busy) |=> !tx_start);

endmodule

// File: tb/tb_cec_dispatch.sv
module tb_cec_dispatch;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       req_valid = 0;
  logic [7:0] req_len = 0, req_svc = 0, req_addr = 0;
  logic       out_load;
  logic [7:0] out_len, out_svc, out_code;
  logic       reg_we = 0, reg_re = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic       err_flag, tx_start;
  logic [7:0] tx_addr;
  logic       tx_done = 0;
  logic [7:0] tx_result = 0;
  logic       rx_start = 0;
  logic [3:0] rx_dest = 0;
  logic       rx_ack;
  logic       rx_done = 0;
  logic [1:0] rx_err = 0;
  logic [4:0] rx_nbytes = 0;

  cec_dispatch dut (.*);

  int checks = 0, fails = 0;
  int attempts = 0, resp_delay = 2;
  logic [7:0] last_addr;
  logic [7:0] resp_q[$];
  logic [23:0] exp_q[$];   // {len, svc, code}
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // reference model pieces, written from the requirements
  function automatic int exp_tries(input int field, input int n_retryable_first);
    int budget = (field > 5) ? 5 : field;
    return (n_retryable_first > budget) ? budget + 1 : n_retryable_first + 1;
  endfunction

  function automatic logic [23:0] cnf_frame(input logic [7:0] code);
    return {8'd3, 8'h01, code};
  endfunction

  // compare every clock: any frame load must match the head of the model queue
  always @(negedge clk) begin
    if (rst_n && out_load) begin
      if (exp_q.size() == 0) chk(0, "R13 unexpected frame", {out_len, out_svc, out_code}, 0);
      else begin
        logic [23:0] e;
        e = exp_q.pop_front();
        chk({out_len, out_svc, out_code} == e, "R9 frame contents/order",
            {out_len, out_svc, out_code}, e);
      end
    end
  end

  // line engine model
  initial begin
    forever begin
      @(negedge clk);
      if (tx_start) begin
        attempts++;
        last_addr = tx_addr;
        repeat (resp_delay) @(posedge clk);
        #1 tx_done = 1;
        tx_result = (resp_q.size() != 0) ? resp_q.pop_front() : 8'h00;
        @(posedge clk);
        #1 tx_done = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1 reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(posedge clk); #1 reg_re = 1; reg_addr = a;
    @(negedge clk); d = reg_rdata;
    @(posedge clk); #1 reg_re = 0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] e, input string req);
    logic [7:0] d;
    rd(a, d);
    chk(d == e, req, d, e);
  endtask

  task automatic send(input logic [7:0] l, input logic [7:0] s, input logic [7:0] ad);
    @(posedge clk); #1 req_valid = 1; req_len = l; req_svc = s; req_addr = ad;
    @(posedge clk); #1 req_valid = 0;
  endtask

  task automatic rx_begin(input logic [3:0] d, input bit exp_ack, input string req);
    @(posedge clk); #1 rx_start = 1; rx_dest = d;
    @(negedge clk); chk(rx_ack == exp_ack, req, rx_ack, exp_ack);
    @(posedge clk); #1 rx_start = 0;
  endtask

  task automatic rx_end(input logic [1:0] e, input logic [4:0] n);
    @(posedge clk); #1 rx_done = 1; rx_err = e; rx_nbytes = n;
    @(posedge clk); #1 rx_done = 0;
  endtask

  task automatic tx_case(input int field, input logic [7:0] codes[$], input logic [7:0] addr,
                         input string req);
    int nretry = 0;
    logic [7:0] last;
    int n;
    resp_q = codes;
    attempts = 0;
    while (nretry < codes.size() &&
           (codes[nretry] == 8'h83 || codes[nretry] == 8'h85 || codes[nretry] == 8'h86)) nretry++;
    n = exp_tries(field, nretry);
    last = (n <= codes.size()) ? codes[n-1] : 8'h00;
    exp_q.push_back(cnf_frame(last));
    send(8'd4, 8'h00, addr);
    cyc(80);
    chk(attempts == n, req, attempts, n);
    chk(last_addr == addr, "R3 tx_addr", last_addr, addr);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    resp_q.delete();
  endtask

  initial begin
    cyc(3);
    #1 rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk(out_load == 0 && tx_start == 0 && err_flag == 0, "R12 reset outputs",
        {out_load, tx_start, err_flag}, 0);
    rd_chk(3'd2, 8'h21, "R12 version");
    rd_chk(3'd3, 8'h00, "R12 control");
    rd_chk(3'd5, 8'h00, "R12 ackl");
    rd_chk(3'd6, 8'h00, "R12 conf");

    // R1 disabled
    attempts = 0;
    exp_q.push_back(cnf_frame(8'h80));
    send(8'd4, 8'h00, 8'h40);
    cyc(10);
    chk(attempts == 0 && exp_q.size() == 0, "R1 off request", attempts, 0);

    wr(3'd4, 8'h00); wr(3'd5, 8'h08); wr(3'd3, 8'h40); wr(3'd6, 8'h02);
    rd_chk(3'd3, 8'h40, "R11 enabled readback");

    // R2 bad service and short count
    exp_q.push_back(cnf_frame(8'h81));
    send(8'd4, 8'h05, 8'h40);
    exp_q.push_back(cnf_frame(8'h81));
    send(8'd2, 8'h00, 8'h40);
    cyc(10);
    chk(attempts == 0 && exp_q.size() == 0, "R2 rejected", attempts, 0);

    tx_case(2, '{8'h00}, 8'h40, "R3 success");
    tx_case(2, '{8'h83, 8'h85, 8'h86, 8'h00}, 8'h41, "R4 budget spent");
    tx_case(2, '{8'h83, 8'h00}, 8'h42, "R4 retry then success");
    wr(3'd6, 8'h07);
    tx_case(7, '{8'h85, 8'h85, 8'h85, 8'h85, 8'h85, 8'h85, 8'h85}, 8'h43, "R6 saturated budget");
    tx_case(7, '{8'h84, 8'h00}, 8'h44, "R5 bit timing");
    tx_case(7, '{8'h82, 8'h00}, 8'h45, "R5 line");

    // R7 request while in flight
    resp_delay = 10; attempts = 0; resp_q = '{8'h00};
    exp_q.push_back(cnf_frame(8'h00));
    send(8'd4, 8'h00, 8'h46);
    cyc(2);
    send(8'd3, 8'h05, 8'h47);
    cyc(30);
    chk(attempts == 1 && exp_q.size() == 0, "R7 ignored request", attempts, 1);
    resp_delay = 2;

    // R8/R9 acknowledge mask
    rx_begin(4'd3, 1, "R8 ack addr3");
    exp_q.push_back({8'd7, 8'h81, 8'h00});
    rx_end(2'd0, 5'd5);
    cyc(4);
    rx_begin(4'd4, 0, "R8 nack addr4");
    rx_end(2'd0, 5'd3);
    rx_begin(4'd15, 0, "R8 broadcast never");
    rx_end(2'd0, 5'd3);
    wr(3'd4, 8'h01);
    rx_begin(4'd8, 1, "R8 high half addr8");
    exp_q.push_back({8'd4, 8'h81, 8'h00});
    rx_end(2'd0, 5'd2);
    cyc(4);
    chk(exp_q.size() == 0, "R9 indications", exp_q.size(), 0);

    // R10 errors, reporting off then on
    rx_begin(4'd3, 1, "R10 ack");
    rx_end(2'd3, 5'd4);
    @(negedge clk);
    chk(err_flag == 1, "R10 flag raised", err_flag, 1);
    rd_chk(3'd1, 8'h03, "R10 error code");
    @(negedge clk);
    chk(err_flag == 0, "R10 flag cleared", err_flag, 0);
    rx_begin(4'd3, 1, "R10 ack");
    exp_q.push_back({8'd6, 8'h81, 8'h00});
    rx_end(2'd2, 5'd4);
    wr(3'd6, 8'h12);
    rx_begin(4'd3, 1, "R10 ack");
    exp_q.push_back({8'd2, 8'h82, 8'h00});
    rx_end(2'd3, 5'd4);
    rx_begin(4'd3, 1, "R10 ack");
    exp_q.push_back({8'd6, 8'h83, 8'h00});
    rx_end(2'd2, 5'd4);
    cyc(4);
    chk(exp_q.size() == 0, "R10 error frames", exp_q.size(), 0);
    rd_chk(3'd1, 8'h02, "R10 last error code");

    // R13 collision
    rx_begin(4'd3, 1, "R13 ack");
    exp_q.push_back(cnf_frame(8'h81));
    exp_q.push_back({8'd5, 8'h81, 8'h00});
    @(posedge clk); #1 req_valid = 1; req_len = 8'd4; req_svc = 8'h09;
    @(posedge clk); #1 req_valid = 0; rx_done = 1; rx_err = 2'd0; rx_nbytes = 5'd3;
    @(negedge clk);
    chk(out_load == 0, "R13 nothing before cnf", out_load, 0);
    @(posedge clk); #1 rx_done = 0;
    @(negedge clk);
    chk(out_load == 1 && out_svc == 8'h01, "R13 cnf first", out_svc, 8'h01);
    @(negedge clk);
    chk(out_load == 1 && out_svc == 8'h81, "R13 ind next", out_svc, 8'h81);
    cyc(3);

    // R11 deferred off
    rx_begin(4'd3, 1, "R11 ack");
    wr(3'd3, 8'h00);
    rd_chk(3'd3, 8'h40, "R11 still on");
    exp_q.push_back({8'd3, 8'h81, 8'h00});
    rx_end(2'd0, 5'd1);
    cyc(3);
    rd_chk(3'd3, 8'h00, "R11 off after idle");
    rx_begin(4'd3, 0, "R11 no ack when off");
    rx_end(2'd0, 5'd1);

    // R12 deferred reset
    wr(3'd3, 8'h40); wr(3'd5, 8'h08);
    resp_delay = 20; resp_q = '{8'h00}; attempts = 0;
    exp_q.push_back(cnf_frame(8'h00));
    send(8'd4, 8'h00, 8'h48);
    cyc(2);
    wr(3'd3, 8'hC0);
    rd_chk(3'd5, 8'h08, "R12 mask kept while busy");
    rd_chk(3'd3, 8'hC0, "R12 reset pending");
    cyc(30);
    rd_chk(3'd5, 8'h00, "R12 mask cleared");
    rd_chk(3'd3, 8'h00, "R12 control cleared");
    rd_chk(3'd6, 8'h00, "R12 conf cleared");
    chk(exp_q.size() == 0, "R12 cnf delivered", exp_q.size(), 0);
    finish_run();
  end

endmodule